// File: doc/BRIEF.md
# Cache Maintenance Range Splitter

This block sits between software-visible cache maintenance requests and a line-range cache engine. A request names an operation (invalidate, clean or flush), a first byte address and an end address that is one past the last byte of interest. The block turns it into a sequence of engine commands. Each command is either a single-line clean-and-invalidate or a range command given as an aligned first line address and an aligned, inclusive last line address.

Range commands are cut so that no single engine operation stalls for long and none crosses a page, because the engine does one translation lookup per range. Invalidate requests must not discard dirty data that shares a line with bytes outside the request, so a partial line at either edge is cleaned and invalidated on its own. Flush cleans and then invalidates each chunk in turn. A write-through override input marks the cache as always clean, which turns clean requests into no-ops.

Requests are accepted on a valid/ready handshake. Commands are presented one at a time and held until the engine acknowledges with a done pulse. A one-cycle completion pulse marks the end of each request.

Top module: `cache_range_splitter`

## Requirements
- R1: `req_ready` is high only when the block is idle. It is low from the cycle after acceptance until the last command of the request has been acknowledged. `req_done` is high for exactly one cycle per accepted request, and no command is presented after it for that request.
- R2: A command, once `cmd_valid` is high, keeps `cmd_kind`, `cmd_addr` and `cmd_last_addr` unchanged until the cycle in which `cmd_done` is sampled high. After that, `cmd_valid` drops.
- R3: Operation codes on `req_op` are 0 = invalidate, 1 = clean, 2 or 3 = flush. Command codes on `cmd_kind` are 0 = single-line clean+invalidate, 1 = range clean, 2 = range invalidate. For a single-line command, `cmd_last_addr` equals `cmd_addr`.
- R4: A range command covering the bytes from chunk start up to an exclusive chunk end carries `cmd_addr` = chunk start and `cmd_last_addr` = chunk end minus 32.
- R5: On invalidate, a start address with nonzero bits [4:0] first produces a single-line command for the line containing it. Processing then continues from the following line.
- R6: On invalidate, after the head step, if the current start is still below the end and the end has nonzero bits [4:0], a single-line command for the line containing the end is issued. The end then rounds down to its line.
- R7: On clean and flush, the start rounds down and the end rounds up to 32-byte boundaries before chunking. Every emitted address has bits [4:0] equal to zero.
- R8: A range command never spans more than 1024 bytes.
- R9: A range command never crosses a 4096-byte page. A chunk ends at the next page start when that comes before the size limit and the request end.
- R10: On flush, each chunk produces a range clean followed by a range invalidate of the same lines, before the next chunk begins.
- R11: With `wt_override` high at acceptance, a clean request emits no command. It pulses `req_done` in the cycle after acceptance. Flush and invalidate are unaffected.
- R12: A request whose range is empty after alignment emits no command and still pulses `req_done` once.
- R13: After reset, `req_ready` is high, and `cmd_valid` and `req_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_override | input | 1 | Cache held write-through; clean requests become no-ops |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code (R3) |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end byte address |
| req_done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command presented to the engine |
| cmd_kind | output | 2 | Command code (R3) |
| cmd_addr | output | AW | Line address, or first line of range |
| cmd_last_addr | output | AW | Inclusive last line of range |
| cmd_done | input | 1 | Engine acknowledge of the presented command |

## Verification
The bench builds the block with its defaults: 32-byte lines, a 1024-byte chunk limit, 4096-byte pages and 32-bit addresses. Requests up to about 5000 bytes long, placed at random offsets, therefore cross several pages and hit both the size cut and the page cut within one request. Directed cases place the ends just inside a line, exactly on page edges and on empty ranges. These cover the head and tail line logic, the rounding and the clipping order. Engine acknowledge delays vary at random, so command holding and the busy window are exercised with both zero and multi-cycle waits.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    OP_INVAL = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    CMD_LINE_CI     = 2'd0,
    CMD_RANGE_CLEAN = 2'd1,
    CMD_RANGE_INVAL = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PICK = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/crs_line_align.sv
// Rounds a byte address down and up to line boundaries (one extra bit for carry).
module crs_line_align #(
  parameter int AW   = 32,
  parameter int LINE = 32
) (
  input  logic [AW-1:0] addr,
  output logic [AW:0]   down,
  output logic [AW:0]   up,
  output logic          partial
);
  localparam int LB = $clog2(LINE);

  logic [AW:0] bumped;

  always_comb begin
    bumped  = {1'b0, addr} + (AW+1)'(LINE - 1);
    down    = {1'b0, addr[AW-1:LB], {LB{1'b0}}};
    up      = {bumped[AW:LB], {LB{1'b0}}};
    partial = |addr[LB-1:0];
  end
endmodule

// File: rtl/crs_chunk_end.sv
// Exclusive end of the next chunk: minimum of request end, size cap and next page.
module crs_chunk_end #(
  parameter int AW    = 32,
  parameter int LINE  = 32,
  parameter int MAXB  = 1024,
  parameter int PAGE  = 4096
) (
  input  logic [AW:0]   cur,
  input  logic [AW:0]   lim,
  output logic [AW:0]   chunk_end,
  output logic [AW-1:0] chunk_last
);
  localparam int PB = $clog2(PAGE);

  logic [AW:0] page_next;
  logic [AW:0] size_next;
  logic [AW:0] pick;
  logic [AW:0] last_full;

  always_comb begin
    page_next = {cur[AW:PB], {PB{1'b0}}} + (AW+1)'(PAGE);
    size_next = cur + (AW+1)'(MAXB);
    pick      = lim;
    if (size_next < pick) pick = size_next;
    if (page_next < pick) pick = page_next;
    chunk_end  = pick;
    last_full  = pick - (AW+1)'(LINE);
    chunk_last = last_full[AW-1:0];
  end
endmodule

// File: rtl/cache_range_splitter.sv
module cache_range_splitter #(
  parameter int AW   = 32,
  parameter int LINE = 32,
  parameter int MAXB = 1024,
  parameter int PAGE = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wt_override,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  output logic          req_done,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_last_addr,
  input  logic          cmd_done
);
  import crs_pkg::*;
  localparam int LB = $clog2(LINE);

  state_e      state;
  logic [1:0]  op_q;
  logic [AW:0] cur_q;
  logic [AW:0] lim_q;
  logic        head_q;
  logic        tail_q;
  logic        phase_q;

  logic [AW:0]   s_down, s_up, e_down, e_up;
  logic          s_part, e_part;
  logic [AW:0]   ce;
  logic [AW-1:0] ce_last;
  logic [AW:0]   lim_line;
  logic          lim_part;
  logic          is_inval_req, is_clean_q, is_inval_q;
  logic [1:0]    range_kind;

  crs_line_align #(.AW(AW), .LINE(LINE)) u_align_start (
    .addr(req_start), .down(s_down), .up(s_up), .partial(s_part)
  );

  crs_line_align #(.AW(AW), .LINE(LINE)) u_align_end (
    .addr(req_end), .down(e_down), .up(e_up), .partial(e_part)
  );

  crs_chunk_end #(.AW(AW), .LINE(LINE), .MAXB(MAXB), .PAGE(PAGE)) u_chunk (
    .cur(cur_q), .lim(lim_q), .chunk_end(ce), .chunk_last(ce_last)
  );

  always_comb begin
    is_inval_req = (req_op == OP_INVAL);
    is_inval_q   = (op_q == OP_INVAL);
    is_clean_q   = (op_q == OP_CLEAN);
    lim_line     = {lim_q[AW:LB], {LB{1'b0}}};
    lim_part     = |lim_q[LB-1:0];
    if (is_inval_q)      range_kind = CMD_RANGE_INVAL;
    else if (is_clean_q) range_kind = CMD_RANGE_CLEAN;
    else                 range_kind = phase_q ? CMD_RANGE_INVAL : CMD_RANGE_CLEAN;
  end

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      op_q          <= OP_INVAL;
      cur_q         <= '0;
      lim_q         <= '0;
      head_q        <= 1'b0;
      tail_q        <= 1'b0;
      phase_q       <= 1'b0;
      req_done      <= 1'b0;
      cmd_valid     <= 1'b0;
      cmd_kind      <= CMD_LINE_CI;
      cmd_addr      <= '0;
      cmd_last_addr <= '0;
    end else begin
      req_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= req_op;
            phase_q <= 1'b0;
            cur_q   <= s_down;
            head_q  <= is_inval_req && s_part;
            tail_q  <= is_inval_req;
            // invalidate keeps the raw end for the tail check; others round up
            lim_q   <= is_inval_req ? {1'b0, req_end} : e_up;
            if (req_op == OP_CLEAN && wt_override) req_done <= 1'b1;
            else                                   state    <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (head_q) begin
            head_q        <= 1'b0;
            cmd_valid     <= 1'b1;
            cmd_kind      <= CMD_LINE_CI;
            cmd_addr      <= cur_q[AW-1:0];
            cmd_last_addr <= cur_q[AW-1:0];
            cur_q         <= cur_q + (AW+1)'(LINE);
            state         <= ST_WAIT;
          end else if (tail_q) begin
            tail_q <= 1'b0;
            if (cur_q < lim_q && lim_part) begin
              cmd_valid     <= 1'b1;
              cmd_kind      <= CMD_LINE_CI;
              cmd_addr      <= lim_line[AW-1:0];
              cmd_last_addr <= lim_line[AW-1:0];
              lim_q         <= lim_line;
              state         <= ST_WAIT;
            end else begin
              lim_q <= lim_line;
            end
          end else if (cur_q < lim_q) begin
            cmd_valid     <= 1'b1;
            cmd_kind      <= range_kind;
            cmd_addr      <= cur_q[AW-1:0];
            cmd_last_addr <= ce_last;
            state         <= ST_WAIT;
            if (op_q[1] && !phase_q) begin
              phase_q <= 1'b1;
            end else begin
              phase_q <= 1'b0;
              cur_q   <= ce;
            end
          end else begin
            req_done <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (cmd_done) begin
            cmd_valid <= 1'b0;
            state     <= ST_PICK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crs_checker.sv
module crs_checker #(
  parameter int AW   = 32,
  parameter int LINE = 32,
  parameter int MAXB = 1024,
  parameter int PAGE = 4096
) (
  input logic          clk,
  input logic          rst,
  input logic          wt_override,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic          req_done,
  input logic          cmd_valid,
  input logic [1:0]    cmd_kind,
  input logic [AW-1:0] cmd_addr,
  input logic [AW-1:0] cmd_last_addr,
  input logic          cmd_done
);
  localparam int LB = $clog2(LINE);
  localparam int PB = $clog2(PAGE);

  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_kind)
      && $stable(cmd_addr) && $stable(cmd_last_addr));

  assert_cmd_drop_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_done |=> !cmd_valid);

  assert_line_single_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind == 2'd0 |-> cmd_last_addr == cmd_addr);

  assert_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_addr[LB-1:0] == '0 && cmd_last_addr[LB-1:0] == '0);

  assert_chunk_size_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind != 2'd0 |-> cmd_last_addr >= cmd_addr
      && (cmd_last_addr - cmd_addr) <= AW'(MAXB - LINE));

  assert_same_page_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind != 2'd0 |-> cmd_addr[AW-1:PB] == cmd_last_addr[AW-1:PB]);

  assert_wt_clean_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && wt_override && req_op == 2'd1 |=> req_done && !cmd_valid);
endmodule

bind cache_range_splitter crs_checker #(
  .AW(AW), .LINE(LINE), .MAXB(MAXB), .PAGE(PAGE)
) u_chk (
  .clk(clk), .rst(rst), .wt_override(wt_override), .req_valid(req_valid),
  .req_ready(req_ready), .req_op(req_op), .req_done(req_done),
  .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
  .cmd_last_addr(cmd_last_addr), .cmd_done(cmd_done)
);

// File: tb/cache_range_splitter_tb.sv
module cache_range_splitter_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wt_override = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_start = '0;
  logic [AW-1:0] req_end = '0;
  logic          req_done;
  logic          cmd_valid;
  logic [1:0]    cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [AW-1:0] cmd_last_addr;
  logic          cmd_done = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [65:0] expq[$];

  always #5 clk = ~clk;

  cache_range_splitter u_dut (
    .clk(clk), .rst(rst), .wt_override(wt_override), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_start(req_start),
    .req_end(req_end), .req_done(req_done), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last_addr(cmd_last_addr),
    .cmd_done(cmd_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual kind=%0d addr=%h last=%h expected kind=%0d addr=%h last=%h",
               tag, act[65:64], act[63:32], act[31:0], exp[65:64], exp[63:32], exp[31:0]);
    end
  endtask

  function automatic logic [65:0] pack_cmd(input int k, input longint a, input longint l);
    return {k[1:0], a[31:0], l[31:0]};
  endfunction

  function automatic longint chunk_end(input longint s, input longint e);
    longint ce = e;
    if (ce > s + 1024) ce = s + 1024;
    if (ce > (s | 4095) + 1) ce = (s | 4095) + 1;
    return ce;
  endfunction

  // reference sequence from R3-style encodings, R4..R12
  task automatic build_exp(input int op, input longint s0, input longint e0, input bit wt);
    longint s = s0;
    longint e = e0;
    expq.delete();
    if (op == 1 && wt) return;
    if (op == 0) begin
      if (s % 32 != 0) begin
        expq.push_back(pack_cmd(0, s & ~longint'(31), s & ~longint'(31)));
        s = (s | 31) + 1;
      end
      if (s < e && e % 32 != 0) begin
        expq.push_back(pack_cmd(0, e & ~longint'(31), e & ~longint'(31)));
        e = e & ~longint'(31);
      end
      while (s < e) begin
        longint ce = chunk_end(s, e);
        expq.push_back(pack_cmd(2, s, ce - 32));
        s = ce;
      end
    end else begin
      s = s & ~longint'(31);
      e = (e + 31) & ~longint'(31);
      while (s < e) begin
        longint ce = chunk_end(s, e);
        expq.push_back(pack_cmd(1, s, ce - 32));
        if (op >= 2) expq.push_back(pack_cmd(2, s, ce - 32));
        s = ce;
      end
    end
  endtask

  task automatic run_req(input string tag, input int op, input longint s, input longint e,
                         input bit wt);
    int guard = 0;
    int ncmd = 0;
    int nexp;
    build_exp(op, s, e, wt);
    nexp = expq.size();
    @(negedge clk);
    while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
    wt_override = wt;
    req_op      = op[1:0];
    req_start   = s[31:0];
    req_end     = e[31:0];
    req_valid   = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!(op == 1 && wt))
      check({tag, " R1 busy after accept"}, {65'd0, req_ready}, 66'd0);
    guard = 0;
    while (!req_done && guard < 20000) begin
      if (cmd_valid) begin
        logic [65:0] exp_cmd = 66'h3_FFFF_FFFF_FFFF_FFFF;
        int d = $urandom % 4;
        if (expq.size() > 0) exp_cmd = expq.pop_front();
        check({tag, " R4 R10 command"}, {cmd_kind, cmd_addr, cmd_last_addr}, exp_cmd);
        check({tag, " R1 ready low while command"}, {65'd0, req_ready}, 66'd0);
        ncmd++;
        repeat (d) begin @(negedge clk); guard++; end
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        check({tag, " R2 valid drops after done"}, {65'd0, cmd_valid}, 66'd0);
      end else begin
        @(negedge clk);
      end
      guard++;
    end
    check({tag, " R1 done seen"}, {65'd0, req_done}, 66'd1);
    check({tag, " command count"}, 66'(ncmd), 66'(nexp));
    @(negedge clk);
    check({tag, " R1 done one cycle"}, {65'd0, req_done}, 66'd0);
  endtask

  initial begin
    int seed_junk;
    seed_junk = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 ready after reset", {65'd0, req_ready}, 66'd1);
    check("R13 cmd idle after reset", {65'd0, cmd_valid}, 66'd0);
    check("R13 done idle after reset", {65'd0, req_done}, 66'd0);

    run_req("R5 R6 inval both edges", 0, 64'h1005, 64'h1843, 1'b0);
    run_req("R5 inval within one line", 0, 64'h1005, 64'h1010, 1'b0);
    run_req("R6 inval partial tail only", 0, 64'h1800, 64'h1C11, 1'b0);
    run_req("R12 inval empty", 0, 64'h2000, 64'h2000, 1'b0);
    run_req("R12 clean empty", 1, 64'h0500, 64'h0500, 1'b0);
    run_req("R7 R9 clean across page", 1, 64'h3FF1, 64'h4403, 1'b0);
    run_req("R8 R10 flush three chunks", 2, 64'h10000, 64'h10C00, 1'b0);
    run_req("R9 R10 flush across page", 3, 64'h10C20, 64'h11840, 1'b0);
    run_req("R11 clean under override", 1, 64'h5000, 64'h7000, 1'b1);
    run_req("R11 flush under override", 2, 64'h5000, 64'h5100, 1'b1);
    run_req("R11 inval under override", 0, 64'h5003, 64'h5100, 1'b1);
    run_req("R3 R4 single page exact", 1, 64'h8000, 64'h9000, 1'b0);

    for (int i = 0; i < 300; i++) begin
      int op = $urandom % 3;
      longint s = longint'($urandom % 32'h80000);
      longint e = s + longint'($urandom % 5000);
      bit wt = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) s = s & ~longint'(4095);
      if (($urandom % 8) == 0) e = (e | 4095) + 1;
      run_req("R4 R7 R8 R9 random", op, s, e, wt);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule